// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges eight reset requests into one synchronous system reset for a small microcontroller core. The requests are an active-low external reset pin, a watchdog overflow, a power-on detector flag, a low-voltage detector flag, the fetch of the illegal opcode 8'hFF, a RAM parity error, a main-oscillator-stop flag and an illegal memory access. The block runs on an always-running clock. The power-on flag acts as its own initialiser.

The external pin passes through a two-flop synchroniser and a minimum-width filter, so that short glitches cannot reset the chip. Every accepted request holds the reset and restarts a fixed reset-processing interval. The reset is released when that interval has run with no request present. On release, a one-cycle strobe tells the core to fetch its start address from the vector bytes at 0000H and 0001H.

While reset is held, the block forces all four oscillator enables off and blocks the external clock input. It forces the clock select to the high-speed on-chip oscillator, drives one safe port pin low and puts every other port pin in high impedance. A sticky cause register records which sources have fired since the last power-on.

Top module: `sys_reset_ctrl`

## Requirements
- R1: While `por_low` is high, `sys_rst` is 1 and `cause` equals 8'h04. Cause bit positions are: 0 external pin, 1 watchdog, 2 power-on, 3 low-voltage, 4 illegal opcode, 5 RAM parity, 6 oscillator stop, 7 illegal access.
- R2: A low pulse on `rst_pin_n` lasting at most FILT_CYCLES clock edges does not assert `sys_rst` and leaves `cause` unchanged.
- R3: A low level on `rst_pin_n` lasting at least FILT_CYCLES+1 edges asserts `sys_rst`, which then stays high while the pin is low. `sys_rst` falls HOLD_CYCLES+1 edges after the first edge that samples the pin high.
- R4: For an internal request (watchdog, low-voltage, power-on, illegal opcode, parity, oscillator stop, illegal access), `sys_rst` rises at the first edge that samples the request. It falls at the HOLD_CYCLES-th edge after the last edge that samples any request, so level requests hold reset as long as they last.
- R5: An edge that samples `fetch_valid` high with `fetch_op` = 8'hFF is an illegal-opcode request. Any other opcode is not a request.
- R6: Each request sets its own `cause` bit, and bits accumulate across resets. Only the power-on request clears `cause`, which it does by setting it back to 8'h04.
- R7: `vec_load` is high for exactly one cycle: the first cycle in which `sys_rst` is low after a reset.
- R8: While `sys_rst` is 1, `osc_main_en`, `osc_sub_en`, `osc_hi_en`, `osc_lo_en` and `ext_clk_en` are all 0. Otherwise the two on-chip enables are 1, and the main, sub and external clock enables follow their request inputs.
- R9: While `sys_rst` is 1, `port_oe` has only bit SAFE_PIN set and `port_out` is all zero. Otherwise both follow their request inputs.
- R10: `clk_sel` is 2'b00 (high-speed on-chip oscillator) while `sys_rst` is 1, and follows `clk_sel_req` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow request |
| por_low | input | 1 | Supply below power-on threshold |
| lvd_low | input | 1 | Supply below low-voltage threshold |
| fetch_valid | input | 1 | Core opcode fetch valid |
| fetch_op | input | 8 | Fetched opcode |
| ram_par_err | input | 1 | RAM parity error |
| osc_stop | input | 1 | Main oscillator stopped |
| bad_access | input | 1 | Illegal memory access |
| xtal_main_req | input | 1 | Requested main crystal enable |
| xtal_sub_req | input | 1 | Requested sub crystal enable |
| ext_clk_req | input | 1 | Requested external clock input enable |
| clk_sel_req | input | 2 | Requested clock source |
| port_oe_req | input | NPORT | Port output enables from port logic |
| port_out_req | input | NPORT | Port output data from port logic |
| sys_rst | output | 1 | System reset, active high |
| vec_load | output | 1 | Load start address from reset vector |
| osc_main_en | output | 1 | Main crystal enable |
| osc_sub_en | output | 1 | Sub crystal enable |
| osc_hi_en | output | 1 | High-speed on-chip oscillator enable |
| osc_lo_en | output | 1 | Low-speed on-chip oscillator enable |
| ext_clk_en | output | 1 | External clock input accepted |
| clk_sel | output | 2 | System clock source select |
| port_oe | output | NPORT | Port output enables |
| port_out | output | NPORT | Port output data |
| cause | output | 8 | Sticky reset cause bits |

## Verification
A wrong filter count shows up at the pin as an early or missing reset within FILT_CYCLES+3 edges of a boundary-width pulse. A wrong hold counter changes the measured length of reset for every source and is caught at the first release. A cause bit that is lost or wrongly cleared shows up at the next `vec_load`, where the scoreboard compares `cause`. A forcing error on oscillators, ports or clock select shows up in the same cycle it is checked, while reset is held.

// File: rtl/sys_reset_ctrl.sv
module sys_reset_ctrl #(
  parameter int FILT_CYCLES = 500,
  parameter int HOLD_CYCLES = 64,
  parameter int NPORT = 16,
  parameter int SAFE_PIN = 0
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             wdt_ovf,
  input  logic             por_low,
  input  logic             lvd_low,
  input  logic             fetch_valid,
  input  logic [7:0]       fetch_op,
  input  logic             ram_par_err,
  input  logic             osc_stop,
  input  logic             bad_access,
  input  logic             xtal_main_req,
  input  logic             xtal_sub_req,
  input  logic             ext_clk_req,
  input  logic [1:0]       clk_sel_req,
  input  logic [NPORT-1:0] port_oe_req,
  input  logic [NPORT-1:0] port_out_req,
  output logic             sys_rst,
  output logic             vec_load,
  output logic             osc_main_en,
  output logic             osc_sub_en,
  output logic             osc_hi_en,
  output logic             osc_lo_en,
  output logic             ext_clk_en,
  output logic [1:0]       clk_sel,
  output logic [NPORT-1:0] port_oe,
  output logic [NPORT-1:0] port_out,
  output logic [7:0]       cause
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [NPORT-1:0] SAFE_MASK = {{(NPORT-1){1'b0}}, 1'b1} << SAFE_PIN;

  logic [1:0]    pin_sync;
  logic [FW-1:0] low_cnt;
  logic [HW-1:0] hold_cnt;
  logic [7:0]    req;
  logic          ext_req, ill_req, any_req, hold_done;

  assign ext_req   = !pin_sync[1] && (low_cnt == FW'(FILT_CYCLES));
  assign ill_req   = fetch_valid && (fetch_op == 8'hFF);
  assign req       = {bad_access, osc_stop, ram_par_err, ill_req, lvd_low, por_low, wdt_ovf, ext_req};
  assign any_req   = |req;
  assign hold_done = (hold_cnt == HW'(HOLD_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (por_low) begin
      pin_sync <= 2'b11;
      low_cnt  <= '0;
    end else begin
      pin_sync <= {pin_sync[0], rst_pin_n};
      if (pin_sync[1])
        low_cnt <= '0;
      else if (low_cnt != FW'(FILT_CYCLES))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    vec_load <= !any_req && sys_rst && hold_done;
    if (any_req) begin
      sys_rst  <= 1'b1;
      hold_cnt <= '0;
    end else if (sys_rst) begin
      if (hold_done) sys_rst <= 1'b0;
      else           hold_cnt <= hold_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por_low) cause <= 8'h04;
    else         cause <= cause | req;
  end

  assign osc_main_en = !sys_rst && xtal_main_req;
  assign osc_sub_en  = !sys_rst && xtal_sub_req;
  assign osc_hi_en   = !sys_rst;
  assign osc_lo_en   = !sys_rst;
  assign ext_clk_en  = !sys_rst && ext_clk_req;
  assign clk_sel     = sys_rst ? 2'b00 : clk_sel_req;
  assign port_oe     = sys_rst ? SAFE_MASK : port_oe_req;
  assign port_out    = sys_rst ? '0 : port_out_req;

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (por_low)
    any_req |=> sys_rst); // R4
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (por_low)
    $fell(sys_rst) |-> $past(!any_req)); // R4
  AST_VEC_AT_RELEASE: assert property (@(posedge clk) disable iff (por_low)
    $fell(sys_rst) |-> vec_load); // R7
  AST_VEC_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (por_low)
    vec_load |-> $fell(sys_rst)); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (por_low)
    !$past(por_low) |-> ((cause & $past(cause)) == $past(cause))); // R6
endmodule

// File: tb/sys_reset_ctrl_tb_top.sv
module sys_reset_ctrl_tb_top;
  localparam int FILT = 20;
  localparam int HOLD = 16;
  localparam int NP = 8;
  localparam int SP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_pin_n = 1'b1, wdt_ovf = 1'b0, por_low = 1'b1, lvd_low = 1'b0;
  logic fetch_valid = 1'b0, ram_par_err = 1'b0, osc_stop = 1'b0, bad_access = 1'b0;
  logic [7:0] fetch_op = 8'h00;
  logic xtal_main_req = 1'b1, xtal_sub_req = 1'b1, ext_clk_req = 1'b1;
  logic [1:0] clk_sel_req = 2'b01;
  logic [NP-1:0] port_oe_req = 8'hA5, port_out_req = 8'hFF;
  logic sys_rst, vec_load, osc_main_en, osc_sub_en, osc_hi_en, osc_lo_en, ext_clk_en;
  logic [1:0] clk_sel;
  logic [NP-1:0] port_oe, port_out;
  logic [7:0] cause;

  sys_reset_ctrl #(.FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD), .NPORT(NP), .SAFE_PIN(SP)) dut_i (
    .clk(clk), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf), .por_low(por_low), .lvd_low(lvd_low),
    .fetch_valid(fetch_valid), .fetch_op(fetch_op), .ram_par_err(ram_par_err),
    .osc_stop(osc_stop), .bad_access(bad_access), .xtal_main_req(xtal_main_req),
    .xtal_sub_req(xtal_sub_req), .ext_clk_req(ext_clk_req), .clk_sel_req(clk_sel_req),
    .port_oe_req(port_oe_req), .port_out_req(port_out_req), .sys_rst(sys_rst),
    .vec_load(vec_load), .osc_main_en(osc_main_en), .osc_sub_en(osc_sub_en),
    .osc_hi_en(osc_hi_en), .osc_lo_en(osc_lo_en), .ext_clk_en(ext_clk_en),
    .clk_sel(clk_sel), .port_oe(port_oe), .port_out(port_out), .cause(cause));

  int total = 0, bad = 0;
  logic [7:0] exp_cause;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each release must carry the expected cause
  always @(negedge clk) begin
    if (vec_load === 1'b1) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected vec_load", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(cause == e, "R6 cause at release", cause, e);
        chk(sys_rst == 1'b0, "R7 vec_load with reset low", sys_rst, 0);
      end
    end
  end

  task automatic forced(input string tag);
    chk(sys_rst == 1'b1, {tag, " R4 reset held"}, sys_rst, 1);
    chk({osc_main_en, osc_sub_en, osc_hi_en, osc_lo_en, ext_clk_en} == 5'b0, {tag, " R8 osc off"},
        {osc_main_en, osc_sub_en, osc_hi_en, osc_lo_en, ext_clk_en}, 0);
    chk(port_oe == 8'h08 && port_out == 8'h00, {tag, " R9 ports forced"}, {port_oe, port_out}, 16'h0800);
    chk(clk_sel == 2'b00, {tag, " R10 clk_sel forced"}, clk_sel, 0);
  endtask

  task automatic freed(input string tag);
    chk({osc_main_en, osc_sub_en, osc_hi_en, osc_lo_en, ext_clk_en} == 5'b11111, {tag, " R8 osc on"},
        {osc_main_en, osc_sub_en, osc_hi_en, osc_lo_en, ext_clk_en}, 5'b11111);
    chk(port_oe == port_oe_req && port_out == port_out_req, {tag, " R9 ports follow"},
        {port_oe, port_out}, {port_oe_req, port_out_req});
    chk(clk_sel == clk_sel_req, {tag, " R10 clk_sel follows"}, clk_sel, clk_sel_req);
  endtask

  task automatic count_hold(output int n);
    n = 0;
    @(negedge clk);
    while (sys_rst) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_src(input int which, input string tag, input logic [7:0] bit_v);
    int n;
    exp_cause = exp_cause | bit_v;
    exp_q.push_back(exp_cause);
    @(negedge clk);
    case (which)
      1: wdt_ovf = 1'b1;
      4: begin fetch_valid = 1'b1; fetch_op = 8'hFF; end
      5: ram_par_err = 1'b1;
      6: osc_stop = 1'b1;
      default: bad_access = 1'b1;
    endcase
    @(negedge clk);
    forced(tag);
    wdt_ovf = 1'b0; fetch_valid = 1'b0; fetch_op = 8'h00;
    ram_par_err = 1'b0; osc_stop = 1'b0; bad_access = 1'b0;
    count_hold(n);
    chk(n == HOLD - 1, {tag, " R4 hold length"}, n, HOLD - 1);
    freed(tag);
  endtask

  task automatic quiet(input int cycles, input string tag);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    chk(!seen, {tag, " no reset"}, seen, 0);
    chk(cause == exp_cause, {tag, " cause unchanged"}, cause, exp_cause);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk(cause == 8'h04, "R1 cause in power-on", cause, 8'h04);
    forced("R1");
    exp_cause = 8'h04;
    exp_q.push_back(exp_cause);
    por_low = 1'b0;
    count_hold(n);
    chk(n == HOLD - 1, "R1 release after power-on", n, HOLD - 1);
    freed("R1");

    pulse_src(1, "watchdog", 8'h02);

    @(negedge clk); fetch_valid = 1'b1; fetch_op = 8'hFE;
    @(negedge clk); fetch_valid = 1'b0; fetch_op = 8'h00;
    quiet(6, "R5 opcode FE");
    @(negedge clk); fetch_valid = 1'b0; fetch_op = 8'hFF;
    @(negedge clk); fetch_op = 8'h00;
    quiet(6, "R5 FF without valid");
    pulse_src(4, "R5 illegal FF", 8'h10);

    rst_pin_n = 1'b0;
    repeat (FILT) @(negedge clk);
    rst_pin_n = 1'b1;
    quiet(FILT, "R2 short pin pulse");

    exp_cause = exp_cause | 8'h01;
    exp_q.push_back(exp_cause);
    rst_pin_n = 1'b0;
    repeat (FILT + 1) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sys_rst == 1'b1, "R3 min width pulse accepted", sys_rst, 1);
    while (sys_rst) @(negedge clk);

    exp_q.push_back(exp_cause);
    rst_pin_n = 1'b0;
    repeat (FILT + 30) @(negedge clk);
    forced("R3 pin held");
    rst_pin_n = 1'b1;
    count_hold(n);
    chk(n == HOLD + 1, "R3 release after pin high", n, HOLD + 1);

    pulse_src(5, "parity", 8'h20);
    clk_sel_req = 2'b10; port_oe_req = 8'h3C; port_out_req = 8'h5A; xtal_sub_req = 1'b1;
    pulse_src(6, "osc stop", 8'h40);
    pulse_src(7, "bad access", 8'h80);

    exp_cause = exp_cause | 8'h08;
    exp_q.push_back(exp_cause);
    @(negedge clk); lvd_low = 1'b1;
    repeat (50) @(negedge clk);
    forced("R4 lvd held");
    lvd_low = 1'b0;
    count_hold(n);
    chk(n == HOLD - 1, "R4 lvd release", n, HOLD - 1);

    chk(cause == 8'hFF, "R6 all causes", cause, 8'hFF);
    exp_cause = 8'h04;
    exp_q.push_back(exp_cause);
    @(negedge clk); por_low = 1'b1;
    repeat (3) @(negedge clk);
    chk(cause == 8'h04, "R6 power-on clears cause", cause, 8'h04);
    por_low = 1'b0;
    count_hold(n);
    chk(n == HOLD - 1, "R1 second release", n, HOLD - 1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 every release seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired R4 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule